// File: doc/BRIEF.md
# Offset Compensation Counter Incrementer

This block keeps two accumulating gauge counters, one for charge and one for discharge. Each counter advances by one on its own normal increment strobe. Once a calibration has finished successfully and the host has enabled compensation, the block also adds correction counts at a steady rate. The rate comes from the measured offset count. A period counter is loaded with that value and steps down on each time-base tick. When it expires, one extra count goes to the counter picked by a select bit, and the period counter is loaded again.

The time-base tick is a one-cycle strobe, nominally every 9.76 ms. The correction period is therefore the offset count multiplied by the tick interval. A measured offset of zero means no correction is needed, so no correction counts are issued. Reading the counters and any compensation done in software belong outside this block.

Top module: `ofs_comp_incr`

## Requirements
- R1: While `rst_n` is low, both counters read 0.
- R2: Each asserted `chg_inc` or `dchg_inc` adds exactly one to its own counter on the next clock edge, whether or not compensation is active.
- R3: While `cal_bad` is 1 (calibration not successful), no correction count is added to either counter.
- R4: While `comp_en` is 0, no correction count is added to either counter.
- R5: Compensation is active when `comp_en`=1, `cal_bad`=0 and `ofs_count`≠0. While it stays active with an unchanged `ofs_count` of N, one correction count is added on every Nth `tick_en` after the period counter was loaded. This repeats indefinitely.
- R6: With `to_dchg`=0 the correction count goes to `chg_cnt`. With `to_dchg`=1 it goes to `dchg_cnt`. The other counter never receives it.
- R7: An `ofs_count` of 0 disables compensation: no correction count is ever added.
- R8: The period counter is loaded with `ofs_count` in any cycle where compensation becomes active, or where `ofs_count` differs from its value in the previous cycle. A tick arriving in a load cycle is not counted.
- R9: When a normal strobe and a correction count target the same counter in the same cycle, that counter advances by 2.
- R10: Both counters wrap modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle time-base tick for the period counter |
| ofs_count | input | OFS_W | Measured offset count; sets the correction period in ticks |
| cal_bad | input | 1 | Calibration status; 0 means a successful calibration |
| comp_en | input | 1 | Compensation enable |
| to_dchg | input | 1 | Correction target: 0 charge, 1 discharge |
| chg_inc | input | 1 | Normal charge increment strobe |
| dchg_inc | input | 1 | Normal discharge increment strobe |
| chg_cnt | output | CNT_W | Charge counter |
| dchg_cnt | output | CNT_W | Discharge counter |

## Verification
The bench keeps `OFS_W` at its default of 24 but uses offsets of 0 to 5. Correction periods are therefore only a few ticks long, and many full periods, reloads and mid-period offset changes fit into a short run. `CNT_W` is set to 8, so the counters wrap within a few hundred cycles. That makes the wrap and the add-by-2 collisions near the wrap point reachable. Ticks arrive either on every cycle or at random, so that load cycles both do and do not coincide with a tick.

// File: rtl/ofs_comp_incr.sv
module ofs_comp_incr #(
  parameter int OFS_W = 24,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [OFS_W-1:0] ofs_count,
  input  logic             cal_bad,
  input  logic             comp_en,
  input  logic             to_dchg,
  input  logic             chg_inc,
  input  logic             dchg_inc,
  output logic [CNT_W-1:0] chg_cnt,
  output logic [CNT_W-1:0] dchg_cnt
);

  localparam logic [OFS_W-1:0] ONE = OFS_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic             active, active_q, reload, fire;
  logic [OFS_W-1:0] ofs_q, remain;

  assign active = comp_en & ~cal_bad & (|ofs_count);
  assign reload = active & (~active_q | (ofs_count != ofs_q));
  assign fire   = active & ~reload & tick_en & (remain <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ofs_q    <= '0;
      remain   <= '0;
    end else begin
      active_q <= active;
      ofs_q    <= ofs_count;
      if (reload || fire)
        remain <= ofs_count;
      else if (active && tick_en)
        remain <= remain - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_cnt  <= '0;
      dchg_cnt <= '0;
    end else begin
      chg_cnt  <= chg_cnt + CNT_W'(chg_inc) + CNT_W'(fire & ~to_dchg);
      dchg_cnt <= dchg_cnt + CNT_W'(dchg_inc) + CNT_W'(fire & to_dchg);
    end
  end

  // R3
  cal_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_bad && !chg_inc && !dchg_inc) |=>
      (chg_cnt == $past(chg_cnt)) && (dchg_cnt == $past(dchg_cnt)));

  // R4
  en_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!comp_en && !chg_inc && !dchg_inc) |=>
      (chg_cnt == $past(chg_cnt)) && (dchg_cnt == $past(dchg_cnt)));

  // R7
  zero_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ofs_count == '0) && !chg_inc && !dchg_inc) |=>
      (chg_cnt == $past(chg_cnt)) && (dchg_cnt == $past(dchg_cnt)));

  // R6
  sel_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!to_dchg && !dchg_inc) |=> dchg_cnt == $past(dchg_cnt));

  // R6
  sel_dchg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (to_dchg && !chg_inc) |=> chg_cnt == $past(chg_cnt));

  // R9
  step_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> CNT_W'(chg_cnt - $past(chg_cnt)) <= TWO);

endmodule

// File: tb/sim_ofs_comp_incr.sv
`timescale 1ns/1ps
module sim_ofs_comp_incr;
  localparam int OFS_W = 24;
  localparam int CNT_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_en = 0, cal_bad = 1, comp_en = 0, to_dchg = 0, chg_inc = 0, dchg_inc = 0;
  logic [OFS_W-1:0] ofs_count = '0;
  logic [CNT_W-1:0] chg_cnt, dchg_cnt;

  ofs_comp_incr #(.OFS_W(OFS_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ofs_count(ofs_count),
    .cal_bad(cal_bad), .comp_en(comp_en), .to_dchg(to_dchg),
    .chg_inc(chg_inc), .dchg_inc(dchg_inc), .chg_cnt(chg_cnt), .dchg_cnt(dchg_cnt));

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  bit finished = 0;
  string tag = "R1";

  int m_rem = 0, m_ofsq = 0, e_chg = 0, e_dchg = 0;
  bit m_actq = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rem = 0; m_ofsq = 0; m_actq = 0; e_chg = 0; e_dchg = 0;
    end else begin
      int ofs;
      bit act, fire;
      ofs  = int'(ofs_count);
      act  = comp_en && !cal_bad && ofs != 0;
      fire = 0;
      if (act && (!m_actq || ofs != m_ofsq)) m_rem = ofs;
      else if (act && tick_en) begin
        if (m_rem <= 1) begin fire = 1; m_rem = ofs; end
        else m_rem = m_rem - 1;
      end
      m_actq = act; m_ofsq = ofs;
      e_chg  = (e_chg + int'(chg_inc) + int'(fire && !to_dchg)) % 256;
      e_dchg = (e_dchg + int'(dchg_inc) + int'(fire && to_dchg)) % 256;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  int saw_double = 0, saw_wrap = 0;

  task automatic run(int n, int tick_mode, bit strobes);
    for (int i = 0; i < n; i++) begin
      int pc;
      @(negedge clk);
      check(tag, int'(chg_cnt), e_chg, "chg_cnt");
      check(tag, int'(dchg_cnt), e_dchg, "dchg_cnt");
      pc = int'(chg_cnt);
      tick_en = (tick_mode == 1) ? 1'b1 : (tick_mode == 2) ? 1'($urandom % 2) : 1'b0;
      if (strobes) begin
        chg_inc  = 1'($urandom % 2);
        dchg_inc = 1'($urandom % 2);
      end
      @(posedge clk); #1;
      if (CNT_W'(chg_cnt - CNT_W'(pc)) == CNT_W'(2)) saw_double++;
      if (int'(chg_cnt) < pc) saw_wrap++;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    check("R1", int'(chg_cnt), 0, "chg_cnt in reset");
    check("R1", int'(dchg_cnt), 0, "dchg_cnt in reset");
    rst_n = 1;
    tag = "R2"; comp_en = 0; cal_bad = 0; ofs_count = 3;
    run(40, 1, 1);
    chg_inc = 0; dchg_inc = 0;
    tag = "R5"; comp_en = 1; to_dchg = 0;
    run(30, 1, 0);
    tag = "R6"; to_dchg = 1; ofs_count = 4;
    run(40, 2, 0);
    tag = "R3"; cal_bad = 1;
    run(30, 1, 1);
    cal_bad = 0; chg_inc = 0; dchg_inc = 0;
    tag = "R4"; comp_en = 0;
    run(20, 1, 0);
    tag = "R8"; comp_en = 1;
    for (int k = 0; k < 12; k++) begin
      ofs_count = OFS_W'(2 + ($urandom % 4));
      to_dchg = 1'($urandom % 2);
      if (k % 4 == 3) comp_en = 0;
      run(1 + ($urandom % 8), (k % 2 == 0) ? 1 : 2, 0);
      comp_en = 1;
    end
    tag = "R7"; ofs_count = 0;
    run(30, 1, 1);
    chg_inc = 0; dchg_inc = 0;
    tag = "R9"; ofs_count = 2; to_dchg = 0; chg_inc = 1; saw_double = 0;
    run(30, 1, 0);
    check("R9", int'(saw_double > 0), 1, "charge counter stepped by 2");
    tag = "R10"; dchg_inc = 1; saw_wrap = 0;
    run(300, 2, 0);
    check("R10", int'(saw_wrap > 0), 1, "charge counter wrapped");
    chg_inc = 0; dchg_inc = 0;
    run(5, 0, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule